// File: doc/BRIEF.md
# Averaging multi-channel ADC scan sequencer

This block drives an eight-channel serial ADC, as used behind a resistive touch panel, from the host side of an SPI link. Software sets an enable mask and, for every channel, the number of settling conversions to throw away and the number of conversions to average. A start pulse then runs one scan. Chip select stays low for the whole scan, and each enabled channel gets a group of back-to-back 24-clock frames. Each frame sends a command byte and then clocks in a 16-bit reading.

Inside a group, every command except the last keeps the converter powered, so the panel plates stay charged. The last command lets the device power itself down. The leading settling readings are discarded. The remaining readings are summed and divided by their count, rounding up. One 16-bit result per enabled channel is written to a numbered slot, in ascending channel order, and a one-cycle done pulse follows the final write.

Top module: `adc_scan_seq`

## Requirements
- R1: Each command byte is, from MSB down: bit 7 = 1, bits 6:4 = channel index, bit 3 = 0, bit 2 = 0, bit 1 = 0, and bit 0 = 1 on every frame of a group except its last frame, where bit 0 = 0.
- R2: A frame is 24 SCLK periods. SCLK idles low. MOSI changes only while SCLK is low and is read on the rising edge, MSB first. The command occupies the first 8 clocks and MOSI is 0 for the remaining 16.
- R3: For each set bit of the enable mask, in ascending channel order, the scan sends exactly skip + average frames for that channel. The skip and average counts are 4-bit fields, and channel c uses bits [4c+3:4c].
- R4: A channel's result is the ceiling of the sum divided by the average count. The sum is taken over its non-skipped readings only, and each reading is the 16-bit big-endian field received in the last 16 clocks shifted right by 3, so the low 3 bits have no effect.
- R5: Result slot k receives the result of the k-th enabled channel, with one write strobe per enabled channel.
- R6: An average count of 0 behaves exactly like an average count of 1.
- R7: Chip select goes low once per non-empty scan, stays low until the last frame of the last group ends, and is high whenever the block is idle.
- R8: A start pulse while a scan is in progress is ignored. This includes a start in the cycle of the final result write.
- R9: Done is high for exactly one cycle. It comes in the cycle after the final result write. With an empty mask it comes with no frame and no write.
- R10: During and after reset, chip select is high, SCLK is low, and busy, done and the write strobe are low.
- R11: SCLK is high for clk_div + 1 clock cycles and low for clk_div + 1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a scan when idle |
| chan_en | input | 8 | Enabled channel mask |
| skip_cfg | input | 32 | Settling frame count, 4 bits per channel |
| avg_cfg | input | 32 | Averaged frame count, 4 bits per channel |
| clk_div | input | 8 | SCLK half period minus one, in clock cycles |
| miso | input | 1 | Serial data from the ADC |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the ADC |
| busy | output | 1 | Scan in progress |
| res_wr | output | 1 | Result slot write strobe |
| res_slot | output | 3 | Result slot index |
| res_data | output | 16 | Averaged result |
| done | output | 1 | Scan finished pulse |

## Verification
The final result write and a new start pulse can land in the same cycle, just before the block returns to idle. The bench watches for the last slot's write strobe and raises start on exactly that cycle. It then requires that no further frame is clocked, that chip select never falls again, and that done pulses once, one cycle after the write. The bench also provokes a second clash. In a group's last frame, the final reading is added in the same cycle that the division starts. A single-frame group, and a group of maximum readings, show whether that last reading reaches the quotient.

// File: rtl/adc_scan_pkg.sv
// Shared constants, state encoding and command builder for the ADC scan sequencer.
// Assumes the converter takes an 8-bit command followed by a 16-bit reading per frame.
package adc_scan_pkg;
    localparam int FRAME_BITS   = 24;
    localparam int CMD_BITS     = 8;
    localparam int FIELD_BITS   = 16;
    localparam int SAMPLE_SHIFT = 3;
    localparam int ADDR_W       = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_DIV,
        ST_DONE
    } seq_state_t;

    // Start bit, channel address, 12-bit differential mode, power held on or released
    function automatic logic [CMD_BITS-1:0] build_cmd(input logic [ADDR_W-1:0] addr,
                                                      input logic keep_on);
        return {1'b1, addr, 1'b0, 1'b0, 1'b0, keep_on};
    endfunction
endpackage

// File: rtl/adc_spi_frame.sv
// Shifts one SPI mode-0 frame: sends a command byte MSB first, then zeros, and
// captures the 16-bit reading in the frame's tail. The reading comes out already
// shifted down past its empty low bits. Assumes go is only raised while the
// engine is idle.
module adc_spi_frame
    import adc_scan_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [DIV_W-1:0]                     half_div,
    input  logic                                 go,
    input  logic [CMD_BITS-1:0]                  cmd,
    input  logic                                 miso,
    output logic                                 sclk,
    output logic                                 mosi,
    output logic                                 fdone,
    output logic [FIELD_BITS-SAMPLE_SHIFT-1:0]   sample
);
    localparam int BIT_W = $clog2(FRAME_BITS);

    logic                  active;
    logic [DIV_W-1:0]      hcnt;
    logic [BIT_W-1:0]      bidx;
    logic [CMD_BITS-1:0]   txsh;
    logic [FIELD_BITS-1:0] rxsh;

    // Half-period timing, bit counting, MOSI launch on falling edges, MISO capture on rising edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            hcnt   <= '0;
            bidx   <= '0;
            txsh   <= '0;
            rxsh   <= '0;
            sclk   <= 1'b0;
            mosi   <= 1'b0;
            fdone  <= 1'b0;
        end else begin
            fdone <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    hcnt   <= '0;
                    bidx   <= BIT_W'(FRAME_BITS - 1);
                    mosi   <= cmd[CMD_BITS-1];
                    txsh   <= {cmd[CMD_BITS-2:0], 1'b0};
                end
            end else if (hcnt != half_div) begin
                hcnt <= hcnt + 1'b1;
            end else begin
                hcnt <= '0;
                if (!sclk) begin
                    sclk <= 1'b1;
                    rxsh <= {rxsh[FIELD_BITS-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bidx == '0) begin
                        active <= 1'b0;
                        fdone  <= 1'b1;
                        mosi   <= 1'b0;
                    end else begin
                        bidx <= bidx - 1'b1;
                        mosi <= txsh[CMD_BITS-1];
                        txsh <= {txsh[CMD_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign sample = rxsh[FIELD_BITS-1:SAMPLE_SHIFT];
endmodule

// File: rtl/adc_group_avg.sv
// Sums the kept readings of one channel group, then forms ceil(sum / count) with a
// one-bit-per-cycle restoring divider. A reading that is added in the same cycle
// as go is included. Assumes a divisor of at least 1 and that clr and add never
// coincide.
module adc_group_avg #(
    parameter int VAL_W = 13,
    parameter int CNT_W = 4,
    parameter int OUT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add,
    input  logic [VAL_W-1:0] val,
    input  logic             go,
    input  logic [CNT_W-1:0] divisor,
    output logic             q_valid,
    output logic [OUT_W-1:0] quotient
);
    localparam int SUM_W  = VAL_W + CNT_W;
    localparam int STEP_W = $clog2(SUM_W + 1);

    logic [SUM_W-1:0]  sum;
    logic [SUM_W-1:0]  sum_upd;
    logic [SUM_W-1:0]  dvd;
    logic [CNT_W-1:0]  dsr;
    logic [CNT_W-1:0]  rem;
    logic [CNT_W:0]    rem_sh;
    logic [STEP_W-1:0] steps;
    logic              run;

    // Running sum including the reading arriving this cycle
    always_comb sum_upd = sum + (add ? SUM_W'(val) : '0);

    // Partial remainder with the next dividend bit brought down
    always_comb rem_sh = {rem, dvd[SUM_W-1]};

    // Accumulation and rounded-up restoring division
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum     <= '0;
            dvd     <= '0;
            dsr     <= '0;
            rem     <= '0;
            steps   <= '0;
            run     <= 1'b0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= 1'b0;
            if (clr) sum <= '0;
            else     sum <= sum_upd;
            if (go) begin
                dvd   <= sum_upd + SUM_W'(divisor) - 1'b1;
                dsr   <= divisor;
                rem   <= '0;
                steps <= STEP_W'(SUM_W);
                run   <= 1'b1;
            end else if (run) begin
                if (rem_sh >= {1'b0, dsr}) begin
                    rem <= CNT_W'(rem_sh - {1'b0, dsr});
                    dvd <= {dvd[SUM_W-2:0], 1'b1};
                end else begin
                    rem <= rem_sh[CNT_W-1:0];
                    dvd <= {dvd[SUM_W-2:0], 1'b0};
                end
                steps <= steps - 1'b1;
                if (steps == STEP_W'(1)) begin
                    run     <= 1'b0;
                    q_valid <= 1'b1;
                end
            end
        end
    end

    assign quotient = OUT_W'(dvd);
endmodule

// File: rtl/adc_scan_seq.sv
// Scan sequencer top. On start, it latches the mask and the per-channel counts,
// walks the enabled channels in ascending order, and issues skip+average frames
// per channel. Power is held on for all but the last frame of a group. Chip
// select stays low across the whole scan. One averaged result per channel goes
// out on the slot write port, then done pulses. Assumes NCH <= 8, since the
// channel address field is 3 bits.
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int CNT_W = 4,
    parameter int DIV_W = 8,
    parameter int RES_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NCH-1:0]       chan_en,
    input  logic [NCH*CNT_W-1:0] skip_cfg,
    input  logic [NCH*CNT_W-1:0] avg_cfg,
    input  logic [DIV_W-1:0]     clk_div,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 cs_n,
    output logic                 mosi,
    output logic                 busy,
    output logic                 res_wr,
    output logic [$clog2(NCH)-1:0] res_slot,
    output logic [RES_W-1:0]     res_data,
    output logic                 done
);
    localparam int SLOT_W = $clog2(NCH);
    localparam int TOT_W  = CNT_W + 1;
    localparam int VAL_W  = FIELD_BITS - SAMPLE_SHIFT;

    seq_state_t           state;
    logic [NCH-1:0]       pend;
    logic [SLOT_W-1:0]    ch;
    logic [SLOT_W-1:0]    slot;
    logic [TOT_W-1:0]     fcnt;
    logic [NCH*CNT_W-1:0] skip_r;
    logic [NCH*CNT_W-1:0] avg_r;
    logic [DIV_W-1:0]     div_r;

    logic [CNT_W-1:0]     cur_skip;
    logic [CNT_W-1:0]     cur_avg;
    logic [CNT_W-1:0]     avg_eff;
    logic [TOT_W-1:0]     total;
    logic                 last_frame;
    logic [NCH-1:0]       pend_next;
    logic [CMD_BITS-1:0]  cmd;
    logic                 frm_go;
    logic                 frm_done;
    logic [VAL_W-1:0]     sample;
    logic                 acc_clr;
    logic                 acc_add;
    logic                 div_go;
    logic                 q_valid;
    logic [RES_W-1:0]     quotient;

    // Index of the lowest set bit of a channel mask
    function automatic logic [SLOT_W-1:0] lowest(input logic [NCH-1:0] m);
        logic [SLOT_W-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) r = SLOT_W'(i);
        end
        return r;
    endfunction

    // Current group's counts, frame bookkeeping and command byte
    always_comb begin
        cur_skip   = skip_r[int'(ch)*CNT_W +: CNT_W];
        cur_avg    = avg_r[int'(ch)*CNT_W +: CNT_W];
        avg_eff    = (cur_avg == '0) ? CNT_W'(1) : cur_avg;
        total      = {1'b0, cur_skip} + {1'b0, avg_eff};
        last_frame = (fcnt == total - 1'b1);
        pend_next  = pend & ~(NCH'(1) << ch);
        cmd        = build_cmd(ADDR_W'(ch), !last_frame);
    end

    // Handshakes toward the frame engine and the averager
    always_comb begin
        frm_go  = (state == ST_SEND);
        acc_clr = (state == ST_SEND) && (fcnt == '0);
        acc_add = (state == ST_WAIT) && frm_done && (fcnt >= {1'b0, cur_skip});
        div_go  = (state == ST_WAIT) && frm_done && last_frame;
    end

    // Scan control: configuration latch, group walk, chip select, result write, done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            pend     <= '0;
            ch       <= '0;
            slot     <= '0;
            fcnt     <= '0;
            skip_r   <= '0;
            avg_r    <= '0;
            div_r    <= '0;
            cs_n     <= 1'b1;
            res_wr   <= 1'b0;
            res_slot <= '0;
            res_data <= '0;
            done     <= 1'b0;
        end else begin
            res_wr <= 1'b0;
            done   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        skip_r <= skip_cfg;
                        avg_r  <= avg_cfg;
                        div_r  <= clk_div;
                        pend   <= chan_en;
                        slot   <= '0;
                        fcnt   <= '0;
                        ch     <= lowest(chan_en);
                        if (chan_en == '0) begin
                            state <= ST_DONE;
                        end else begin
                            cs_n  <= 1'b0;
                            state <= ST_SEND;
                        end
                    end
                end
                ST_SEND: state <= ST_WAIT;
                ST_WAIT: begin
                    if (frm_done) begin
                        if (last_frame) begin
                            state <= ST_DIV;
                            if (pend_next == '0) cs_n <= 1'b1;
                        end else begin
                            fcnt  <= fcnt + 1'b1;
                            state <= ST_SEND;
                        end
                    end
                end
                ST_DIV: begin
                    if (q_valid) begin
                        res_wr   <= 1'b1;
                        res_slot <= slot;
                        res_data <= quotient;
                        slot     <= slot + 1'b1;
                        pend     <= pend_next;
                        fcnt     <= '0;
                        ch       <= lowest(pend_next);
                        state    <= (pend_next == '0) ? ST_DONE : ST_SEND;
                    end
                end
                ST_DONE: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    adc_spi_frame #(
        .DIV_W(DIV_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (div_r),
        .go       (frm_go),
        .cmd      (cmd),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .fdone    (frm_done),
        .sample   (sample)
    );

    adc_group_avg #(
        .VAL_W(VAL_W),
        .CNT_W(CNT_W),
        .OUT_W(RES_W)
    ) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .add      (acc_add),
        .val      (sample),
        .go       (div_go),
        .divisor  (avg_eff),
        .q_valid  (q_valid),
        .quotient (quotient)
    );
endmodule

// File: rtl/adc_scan_seq_chk.sv
// Protocol checker for the scan sequencer, bound onto every instance of the top.
// It observes only the top's ports.
module adc_scan_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic cs_n,
    input logic sclk,
    input logic mosi,
    input logic res_wr,
    input logic done
);
    // R7
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> cs_n);

    // R2
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);

    // R2
    mosi_launch_chk: assert property (@(posedge clk) disable iff (!rst_n) !$stable(mosi) |-> !sclk);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

    // R9
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) res_wr |-> !done);

    // R5
    wr_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n) res_wr |-> busy);
endmodule

bind adc_scan_seq adc_scan_seq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .mosi   (mosi),
    .res_wr (res_wr),
    .done   (done)
);

// File: tb/adc_scan_seq_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: the scan task predicts the command stream and the slot
// results, a modelled ADC checks each command it receives, and a monitor checks
// every slot write.
module adc_scan_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  chan_en = '0;
    logic [31:0] skip_cfg = '0;
    logic [31:0] avg_cfg = '0;
    logic [7:0]  clk_div = '0;
    logic        miso = 1'b0;
    logic        sclk, cs_n, mosi, busy, res_wr, done;
    logic [2:0]  res_slot;
    logic [15:0] res_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] exp_cmd[$];
    int         exp_slot[$];
    int         exp_data[$];

    int cur_seed = 0;
    string cur_tag = "";
    int cyc = 0;
    int done_cnt = 0, wr_cnt = 0, cs_fall_cnt = 0, cs_rise_cnt = 0;
    int last_wr_cyc = 0, done_cyc = 0, hi_run = 0, last_hi = 0;
    logic prev_cs = 1'b1;

    always #2 clk = ~clk;

    adc_scan_seq u_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_en(chan_en),
        .skip_cfg(skip_cfg), .avg_cfg(avg_cfg), .clk_div(clk_div), .miso(miso),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .res_wr(res_wr),
        .res_slot(res_slot), .res_data(res_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, cur_tag, act, expv);
        end
    endtask

    // Reading the modelled ADC returns for frame g of a scan
    function automatic int sval(input int seed, input int g);
        if (seed == 999) return 4095;
        return (seed * 113 + g * 517 + 29) % 4096;
    endfunction

    // Modelled ADC: capture command, answer with {0, reading, 3'b101}, compare command (R1, R2, R3)
    int pos = 0, g = 0;
    logic [7:0]  cmd_rx = '0;
    logic [15:0] field = '0;
    always @(posedge sclk or negedge cs_n) begin
        if (!sclk) begin
            pos = 0;
            g = 0;
        end else begin
            if (pos < 8) cmd_rx[7-pos] = mosi;
            pos++;
            if (pos == 8) field = {1'b0, 12'(sval(cur_seed, g)), 3'b101};
            if (pos == 24) begin
                if (exp_cmd.size() == 0) begin
                    check(1'b0, "R3/R8 unexpected frame", int'(cmd_rx), -1);
                end else begin
                    logic [7:0] e;
                    e = exp_cmd.pop_front();
                    check(cmd_rx == e, "R1/R3 command byte", int'(cmd_rx), int'(e));
                end
                g++;
                pos = 0;
            end
        end
    end

    // MISO changes after each falling SCLK edge: zeros under the command, then the field
    always @(negedge sclk or negedge cs_n) begin
        miso = (pos >= 8 && pos < 24) ? field[23-pos] : 1'b0;
    end

    // Monitor: result scoreboard, done/cs edge counts, SCLK high-time measure
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (res_wr) begin
                wr_cnt++;
                last_wr_cyc = cyc;
                if (exp_data.size() == 0) begin
                    check(1'b0, "R5 unexpected write", int'(res_slot), -1);
                end else begin
                    int es, ed;
                    es = exp_slot.pop_front();
                    ed = exp_data.pop_front();
                    check(int'(res_slot) == es, "R5 slot index", int'(res_slot), es);
                    check(int'(res_data) == ed, "R4/R6 averaged result", int'(res_data), ed);
                end
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            if (prev_cs && !cs_n) cs_fall_cnt++;
            if (!prev_cs && cs_n) cs_rise_cnt++;
            if (sclk) hi_run++;
            else if (hi_run > 0) begin
                last_hi = hi_run;
                hi_run = 0;
            end
        end
        prev_cs = cs_n;
    end

    // Driver: predicts commands and results, runs one scan.
    // mode 1 = start again mid-scan, mode 2 = start in the final write cycle (R8)
    task automatic run_scan(input logic [7:0] mask, input logic [31:0] sk, input logic [31:0] av,
                            input logic [7:0] dv, input int seed, input int mode, input string tag);
        int gg = 0, slot = 0, nwr = 0;
        int d0, f0, r0, w0;
        cur_tag = tag;
        for (int c = 0; c < 8; c++) begin
            if (mask[c]) begin
                int s, a, n, sum;
                s = int'(sk[c*4 +: 4]);
                a = int'(av[c*4 +: 4]);
                if (a == 0) a = 1;
                n = s + a;
                sum = 0;
                for (int i = 0; i < n; i++) begin
                    exp_cmd.push_back({1'b1, 3'(c), 3'b000, (i == n - 1) ? 1'b0 : 1'b1});
                    if (i >= s) sum += sval(seed, gg);
                    gg++;
                end
                exp_slot.push_back(slot);
                exp_data.push_back((sum + a - 1) / a);
                slot++;
            end
        end
        nwr = slot;
        cur_seed = seed;
        chan_en = mask;
        skip_cfg = sk;
        avg_cfg = av;
        clk_div = dv;
        d0 = done_cnt; f0 = cs_fall_cnt; r0 = cs_rise_cnt; w0 = wr_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (mode == 1) begin
            repeat (60) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        if (mode == 2) begin
            while (!(res_wr && int'(res_slot) == nwr - 1)) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (40) @(negedge clk);
        check(done_cnt - d0 == 1, "R8/R9 done pulse count", done_cnt - d0, 1);
        check(exp_cmd.size() == 0, "R3 frames left unsent", exp_cmd.size(), 0);
        check(exp_data.size() == 0, "R5 results left unwritten", exp_data.size(), 0);
        check(wr_cnt - w0 == nwr, "R5 write count", wr_cnt - w0, nwr);
        check(cs_n == 1'b1 && busy == 1'b0, "R7 idle after scan", int'(cs_n), 1);
        if (nwr > 0) begin
            check(cs_fall_cnt - f0 == 1, "R7/R8 chip select falls", cs_fall_cnt - f0, 1);
            check(cs_rise_cnt - r0 == 1, "R7 chip select rises", cs_rise_cnt - r0, 1);
            check(done_cyc == last_wr_cyc + 1, "R9 done after last write", done_cyc - last_wr_cyc, 1);
            check(last_hi == int'(dv) + 1, "R11 SCLK high time", last_hi, int'(dv) + 1);
        end else begin
            check(cs_fall_cnt - f0 == 0, "R9 empty mask no frame", cs_fall_cnt - f0, 0);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        cur_tag = "reset";
        check(cs_n == 1'b1, "R10 cs_n in reset", int'(cs_n), 1);
        check(sclk == 1'b0, "R10 sclk in reset", int'(sclk), 0);
        check(busy == 1'b0 && done == 1'b0 && res_wr == 1'b0, "R10 status in reset",
              int'({busy, done, res_wr}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n == 1'b1 && busy == 1'b0, "R10 idle after reset", int'(cs_n), 1);
        // four sparse channels, assorted counts, fastest clock (R1 R3 R4 R5)
        run_scan(8'hA6, 32'h1020_0310, 32'h3040_0250, 8'd0, 1, 0, "scanA");
        // all channels, two zero averages (R6), divided clock (R11), restart mid-scan (R8)
        run_scan(8'hFF, 32'h0123_0210, 32'h2103_4051, 8'd2, 2, 1, "scanB_R6");
        // single one-frame group with full-scale reading, start on final write (R8)
        run_scan(8'h01, 32'h0000_0000, 32'h0000_0001, 8'd0, 999, 2, "scanC");
        // empty mask (R9)
        run_scan(8'h00, 32'h0000_0000, 32'h0000_0000, 8'd0, 3, 0, "scanD");
        // top channel, maximum counts, full-scale readings
        run_scan(8'h80, 32'hF000_0000, 32'hF000_0000, 8'd1, 999, 0, "scanE");
        // mixed readings with maximum counts on two channels
        run_scan(8'h41, 32'h0F00_0002, 32'h0700_000F, 8'd0, 7, 0, "scanF");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an overlong run counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog %s actual=timeout expected=finish", cur_tag);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule